// File: doc/BRIEF.md
# Trigger Accept Sequencer and Header Broadcaster

This block converts a trigger request into an accept window for downstream readout modules, and into a trigger strobe one clock long for the front-end interface. While the window is open it drives a three-word event header onto an 8-bit bus. Each word carries a 2-bit tag that tells receivers which field is on the bus. Outside the header the tag reads 11, which marks the bus as invalid.

The block has two modes. In external mode, a trigger-system accept flag opens the window, and the readout type, event number and bunch number presented with that flag are latched. The window then stays open until the trigger system confirms or aborts it. In local mode, the block merges three request sources and keeps its own event counter, which the host can preload. It also keeps a free-running bunch-crossing counter. The window then lasts either a fixed number of clocks or as long as the request is held.

A status flag records whether the most recent window ended in an abort.

Top module: `trig_accept_seq`

## Requirements
- R1: On the clock where the accept line rises, the tag reads 00 with the readout type on the bus. On the next clock it reads 01 with the event number. On the clock after that it reads 10 with the bunch number. Each step happens only while the accept line is still high.
- R2: The tag reads 11 and the bus reads 0 whenever the accept line is low, and also after the three header words have been sent.
- R3: The trigger strobe is high for exactly one clock per accepted trigger, on the same clock that the accept line rises.
- R4: In external mode (mode_local = 0), a high sys_accept with the window closed opens it on the next clock and latches sys_rtype, sys_evt and sys_bx as the header. The window closes on the clock after sys_confirm or sys_abort is sampled high.
- R5: In local mode with var_len_en = 0, the accept line stays high for exactly ACC_LEN clocks (default 104), unless it is aborted first.
- R6: In local mode with var_len_en = 1, the accept line opens on the clock after the request rises. It closes on the clock after the request is first sampled low, so it stays high for as many clocks as the request did.
- R7: In local mode, reg_trig, ext_trig and btn_trig are OR-ed into one request. Only a rising edge of that request starts a window.
- R8: The local event number in the header is the counter value, which then increments by one modulo 256 on every local trigger, aborted ones included. A host_evt_load pulse sets the value that the next trigger uses. The counter resets to 0.
- R9: The bunch counter resets to 0 and advances once per clock. It wraps from BX_LAST (default 219) to 0. A local header carries its value from the clock on which the request was sampled.
- R10: The last-aborted flag sets on the clock after sys_abort is sampled high while a window is open. It clears when the next window opens.
- R11: A request or sys_accept that arrives while a window is open is ignored. It produces no strobe, no restart and no header change.
- R12: After reset the accept line, the strobe and the flag are low, the tag reads 11 and the bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_local | input | 1 | 1 = local mode, 0 = external mode |
| var_len_en | input | 1 | Local mode: accept follows the request length |
| reg_trig | input | 1 | Register-driven trigger request |
| ext_trig | input | 1 | External trigger request |
| btn_trig | input | 1 | Push-button trigger request |
| sys_accept | input | 1 | Trigger-system accept flag |
| sys_confirm | input | 1 | Trigger-system validation, closes the window |
| sys_abort | input | 1 | Abort, closes the window in either mode |
| sys_rtype | input | 8 | Trigger-system readout type |
| sys_evt | input | 8 | Trigger-system event number |
| sys_bx | input | 8 | Trigger-system bunch number |
| loc_rtype | input | 8 | Readout type used in local mode |
| host_evt_load | input | 1 | Load the local event counter |
| host_evt_value | input | 8 | Value for the local event counter |
| accept_o | output | 1 | Accept window to readout modules |
| trig_strobe_o | output | 1 | One-clock trigger strobe to the front end |
| hdr_data_o | output | 8 | Header data bus |
| hdr_code_o | output | 2 | Header word tag, 11 = invalid |
| last_aborted_o | output | 1 | The previous window ended in an abort |

## Verification
Every output is registered once from the sampled inputs. A request or flag sampled at one edge therefore shows up as a rising accept line, the strobe and tag 00 right after that edge. Tags 01 and 10 follow one and two clocks later, and a close or abort shows one clock after it is sampled. The bench drives inputs just after the falling edge. It advances a behavioural model at each rising edge and compares all five outputs with that model at every falling edge, so each result is checked in the cycle it is due. Directed checks then confirm window lengths, event numbers, the ignored requests and the abort flag once the window has settled.

// File: rtl/trig_accept_seq.sv
module trig_accept_seq #(
  parameter int DW      = 8,
  parameter int BX_LAST = 219,
  parameter int ACC_LEN = 104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_local,
  input  logic          var_len_en,
  input  logic          reg_trig,
  input  logic          ext_trig,
  input  logic          btn_trig,
  input  logic          sys_accept,
  input  logic          sys_confirm,
  input  logic          sys_abort,
  input  logic [DW-1:0] sys_rtype,
  input  logic [DW-1:0] sys_evt,
  input  logic [DW-1:0] sys_bx,
  input  logic [DW-1:0] loc_rtype,
  input  logic          host_evt_load,
  input  logic [DW-1:0] host_evt_value,
  output logic          accept_o,
  output logic          trig_strobe_o,
  output logic [DW-1:0] hdr_data_o,
  output logic [1:0]    hdr_code_o,
  output logic          last_aborted_o
);
  localparam int LW = $clog2(ACC_LEN + 1);
  localparam int BW = $clog2(BX_LAST + 1);

  logic          open_q, strobe_q, abort_q, req_q;
  logic [1:0]    word_q;
  logic [LW-1:0] len_q;
  logic [BW-1:0] bx_cnt;
  logic [DW-1:0] t_q, e_q, b_q, evt_cnt;
  logic          req, start, expire, close;
  logic [DW-1:0] evt_next;

  assign req      = reg_trig | ext_trig | btn_trig;
  assign start    = !open_q && (mode_local ? (req && !req_q) : sys_accept);
  assign expire   = mode_local ? (var_len_en ? !req : (len_q == LW'(ACC_LEN - 1)))
                               : sys_confirm;
  assign close    = open_q && (sys_abort || expire);
  assign evt_next = host_evt_load ? host_evt_value : evt_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bx_cnt <= '0;
    else        bx_cnt <= (bx_cnt == BW'(BX_LAST)) ? '0 : bx_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      strobe_q <= 1'b0;
      abort_q  <= 1'b0;
      req_q    <= 1'b0;
      word_q   <= 2'd0;
      len_q    <= '0;
      evt_cnt  <= '0;
      t_q      <= '0;
      e_q      <= '0;
      b_q      <= '0;
    end else begin
      req_q    <= req;
      strobe_q <= start;
      evt_cnt  <= evt_next + DW'(start && mode_local);
      if (start) begin
        open_q  <= 1'b1;
        word_q  <= 2'd0;
        len_q   <= '0;
        abort_q <= 1'b0;
        t_q     <= mode_local ? loc_rtype : sys_rtype;
        e_q     <= mode_local ? evt_next : sys_evt;
        b_q     <= mode_local ? DW'(bx_cnt) : sys_bx;
      end else if (close) begin
        open_q <= 1'b0;
        if (sys_abort) abort_q <= 1'b1;
      end else if (open_q) begin
        if (len_q != LW'(ACC_LEN - 1)) len_q <= len_q + 1'b1;
        if (word_q != 2'd3) word_q <= word_q + 2'd1;
      end
    end
  end

  assign accept_o       = open_q;
  assign trig_strobe_o  = strobe_q;
  assign last_aborted_o = abort_q;
  assign hdr_code_o     = open_q ? word_q : 2'b11;

  always_comb begin
    case (hdr_code_o)
      2'b00:   hdr_data_o = t_q;
      2'b01:   hdr_data_o = e_q;
      2'b10:   hdr_data_o = b_q;
      default: hdr_data_o = '0;
    endcase
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe_o |=> !trig_strobe_o); // R3
  AST_STROBE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe_o |-> accept_o && hdr_code_o == 2'b00); // R1
  AST_CODE_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && hdr_code_o == 2'b00 |=> !accept_o || hdr_code_o == 2'b01); // R1
  AST_CODE_STEP2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && hdr_code_o == 2'b01 |=> !accept_o || hdr_code_o == 2'b10); // R1
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && $past(accept_o) |-> !trig_strobe_o); // R11
  AST_BX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bx_cnt <= BW'(BX_LAST)); // R9
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && sys_abort |=> last_aborted_o && !accept_o); // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trig_strobe_o |-> !last_aborted_o); // R10
  AST_CONFIRM_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && !mode_local && sys_confirm |=> !accept_o); // R4
endmodule

// File: tb/trig_accept_seq_tb.sv
module trig_accept_seq_tb;
  localparam int ACC_LEN = 104;
  localparam int BX_LAST = 219;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_local = 0, var_len_en = 0, reg_trig = 0, ext_trig = 0, btn_trig = 0;
  logic sys_accept = 0, sys_confirm = 0, sys_abort = 0, host_evt_load = 0;
  logic [7:0] sys_rtype = 0, sys_evt = 0, sys_bx = 0, loc_rtype = 0, host_evt_value = 0;
  logic accept_o, trig_strobe_o, last_aborted_o;
  logic [7:0] hdr_data_o;
  logic [1:0] hdr_code_o;

  always #2 clk = ~clk;

  trig_accept_seq #(.DW(8), .BX_LAST(BX_LAST), .ACC_LEN(ACC_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_local(mode_local), .var_len_en(var_len_en),
    .reg_trig(reg_trig), .ext_trig(ext_trig), .btn_trig(btn_trig),
    .sys_accept(sys_accept), .sys_confirm(sys_confirm), .sys_abort(sys_abort),
    .sys_rtype(sys_rtype), .sys_evt(sys_evt), .sys_bx(sys_bx), .loc_rtype(loc_rtype),
    .host_evt_load(host_evt_load), .host_evt_value(host_evt_value),
    .accept_o(accept_o), .trig_strobe_o(trig_strobe_o), .hdr_data_o(hdr_data_o),
    .hdr_code_o(hdr_code_o), .last_aborted_o(last_aborted_o));

  int compared = 0, mismatched = 0;

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_acc, m_len, m_idx, m_flag, m_strobe, m_evt, m_bx, m_reqp, m_ld, m_req;
  int m_hdr[3];
  bit m_valid, m_local, m_var, m_st, m_cl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_len = 0; m_idx = 0; m_flag = 0; m_strobe = 0;
      m_evt = 0; m_bx = 0; m_reqp = 0; m_valid = 1;
    end else begin
      m_local = mode_local; m_var = var_len_en;
      m_req = (reg_trig || ext_trig || btn_trig) ? 1 : 0;
      m_ld  = host_evt_load ? int'(host_evt_value) : m_evt;
      m_st  = (m_acc == 0) && (mode_local ? (m_req == 1 && m_reqp == 0) : sys_accept);
      m_cl  = (m_acc == 1) && (sys_abort ||
              (mode_local ? (var_len_en ? m_req == 0 : m_len == ACC_LEN) : sys_confirm));
      m_strobe = m_st;
      if (m_st) begin
        m_acc = 1; m_len = 1; m_idx = 0; m_flag = 0;
        m_hdr[0] = mode_local ? loc_rtype : sys_rtype;
        m_hdr[1] = mode_local ? m_ld : sys_evt;
        m_hdr[2] = mode_local ? m_bx : sys_bx;
        m_evt = mode_local ? (m_ld + 1) % 256 : m_ld;
      end else begin
        m_evt = m_ld;
        if (m_cl) begin
          m_acc = 0;
          if (sys_abort) m_flag = 1;
        end else if (m_acc == 1) begin
          m_len++; m_idx++;
        end
      end
      m_bx = (m_bx == BX_LAST) ? 0 : m_bx + 1;
      m_reqp = m_req;
    end
  end

  int strobes = 0, last_evt = -1, last_bx = -1, acc_run = 0, last_len = 0;

  always @(negedge clk) begin
    int ec, ed;
    if (m_valid && rst_n) begin
      ec = (m_acc == 1 && m_idx < 3) ? m_idx : 3;
      ed = (ec < 3) ? m_hdr[ec] : 0;
      chk(m_local ? (m_var ? "R6" : "R5") : "R4", accept_o, m_acc);
      chk("R3", trig_strobe_o, m_strobe);
      chk(ec == 3 ? "R2" : "R1", hdr_code_o, ec);
      chk(ec == 0 ? "R1" : ec == 1 ? "R8" : ec == 2 ? "R9" : "R2", hdr_data_o, ed);
      chk("R10", last_aborted_o, m_flag);
    end
    if (trig_strobe_o) strobes++;
    if (accept_o && hdr_code_o == 2'b01) last_evt = hdr_data_o;
    if (accept_o && hdr_code_o == 2'b10) last_bx = hdr_data_o;
    if (accept_o) acc_run++;
    else if (acc_run > 0) begin last_len = acc_run; acc_run = 0; end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int s0;
    cyc(3);
    chk("R12", accept_o, 0); chk("R12", hdr_code_o, 3);
    chk("R12", hdr_data_o, 0); chk("R12", last_aborted_o, 0);
    chk("R12", trig_strobe_o, 0);
    rst_n = 1;
    cyc(2);
    // external mode
    sys_rtype = 8'hA5; sys_evt = 8'h12; sys_bx = 8'h34;
    sys_accept = 1; cyc(1); sys_accept = 0;
    cyc(5);
    chk("R4", last_evt, 8'h12); chk("R4", last_bx, 8'h34);
    sys_confirm = 1; cyc(1); sys_confirm = 0; cyc(2);
    chk("R4", accept_o, 0);
    sys_evt = 8'h40;
    sys_accept = 1; cyc(1); sys_accept = 0; sys_abort = 1; cyc(1); sys_abort = 0;
    cyc(2);
    chk("R10", last_aborted_o, 1);
    s0 = strobes;
    sys_evt = 8'h41;
    sys_accept = 1; cyc(1); sys_accept = 0; cyc(2);
    chk("R10", last_aborted_o, 0);
    sys_evt = 8'h99;
    sys_accept = 1; cyc(1); sys_accept = 0; cyc(2);
    chk("R11", strobes - s0, 1); chk("R11", last_evt, 8'h41);
    sys_confirm = 1; cyc(1); sys_confirm = 0; cyc(2);
    // local fixed length
    mode_local = 1; loc_rtype = 8'h3C;
    host_evt_load = 1; host_evt_value = 8'hFE; cyc(1); host_evt_load = 0;
    s0 = strobes;
    btn_trig = 1; cyc(1); btn_trig = 0; cyc(110);
    chk("R8", last_evt, 8'hFE); chk("R5", last_len, ACC_LEN);
    reg_trig = 1; cyc(1); reg_trig = 0; cyc(10);
    ext_trig = 1; cyc(1); ext_trig = 0; cyc(100);
    chk("R11", strobes - s0, 2); chk("R8", last_evt, 8'hFF);
    ext_trig = 1; cyc(1); ext_trig = 0; cyc(20);
    sys_abort = 1; cyc(1); sys_abort = 0; cyc(2);
    chk("R10", last_aborted_o, 1); chk("R8", last_evt, 8'h00);
    chk("R7", strobes - s0, 3);
    chk("R9", last_bx <= BX_LAST, 1);
    btn_trig = 1; cyc(1); btn_trig = 0; cyc(110);
    chk("R8", last_evt, 8'h01); chk("R10", last_aborted_o, 0);
    // local variable length
    var_len_en = 1; s0 = strobes;
    reg_trig = 1; cyc(5); reg_trig = 0; cyc(3);
    chk("R6", last_len, 5);
    reg_trig = 1; cyc(2); reg_trig = 0; cyc(1);
    ext_trig = 1; cyc(3); ext_trig = 0; cyc(3);
    chk("R6", last_len, 3); chk("R7", strobes - s0, 3);
    cyc(230);
    btn_trig = 1; cyc(4); btn_trig = 0; cyc(4);
    chk("R9", last_bx <= BX_LAST, 1); chk("R8", last_evt, 8'h05);
    cyc(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule